// File: doc/BRIEF.md
# Floating-Point Exception Dispatch Controller

This block sits beside the arithmetic datapath of a floating-point unit. When an operation finishes, it decides three things. First, whether the result may be written to its destination. Second, whether the exception is reported at once after the instruction (post-instruction) or held until the next floating-point instruction begins (pre-instruction). Third, which handler gets control: resume the normal flow, the underflow handler, the overflow handler or the inexact handler. It computes no numeric result and fetches no vectors.

The destination type decides how the exception is reported. A floating-point register destination is left untouched and its exception waits in a single pending slot. An integer register or memory destination still receives the result and reports at once. A move-out operation that traps writes its operand first and raises the request one cycle later. The handler comes from a fixed priority chain over the enable byte of the control register and the accrued byte of the status register.

A multiply whose result is normalized but carries a biased exponent of zero is reported as an underflow. This quirk is kept on purpose and can be switched off with a parameter.

Top module: `fpx_dispatch`

## Requirements
- R1: An exception event is an operation (`op_valid_i`=1) with the underflow bit (bit 1) or the overflow bit (bit 2) of `exc_flags_i` set. Bit 0 (inexact) on its own is not an event. An operation with no event produces `wr_en_o`=1 one cycle later for every destination and raises no request.
- R2: `dest_i` encoding: 0 = floating-point register, 1 = integer register, 2 and 3 = memory. For an event with destination 0, `wr_en_o` stays 0 and no request is raised in the following cycle; the exception becomes pending.
- R3: A pending exception raises `pre_req_o` in the cycle after `next_fp_i` is sampled high. It carries the handler chosen when the exception occurred, and the pending slot is then empty, so a further `next_fp_i` raises nothing.
- R4: For an event with destination 1, 2 or 3, `wr_en_o` and `post_req_o` are both 1 one cycle after the operation, except in the move-out case of R5.
- R5: For a move-out operation (`move_out_i`=1) with an event and a non-resume handler, `wr_en_o`=1 with `post_req_o`=0 one cycle after the operation, and `post_req_o`=1 in the cycle after that.
- R6: `handler_o` encoding: 0 = resume, 1 = underflow, 2 = overflow, 3 = inexact. The choice is made in this order: enable bit 1 (underflow) gives 1; otherwise enable bit 2 (overflow) gives 2; otherwise enable bit 0 (inexact) together with accrued bit 0 (inexact) gives 3; otherwise 0. The other bits of both bytes are ignored.
- R7: `handler_o` is nonzero only in a cycle where a request is high. `pre_req_o` and `post_req_o` are never high together, and each request lasts one cycle.
- R8: With `MUL_QUIRK`=1, an operation with `mul_i`=1, `res_norm_i`=1 and `res_exp_i`=0 counts as an underflow event even when `exc_flags_i` is 0. A nonzero exponent or a result that is not normalized does not trigger it.
- R9: A new destination-0 event replaces the pending exception. If it arrives in the same cycle as `next_fp_i` while an older exception is pending, the older one is raised and the new one stays pending.
- R10: When a post-instruction request and a pending pre-instruction request fall due in the same cycle, the post request goes first and the pre request follows in the next cycle. No operation with an event may target destination 1–3 in the cycle right after a trapping move-out.
- R11: While `rst_ni` is low, all outputs are 0 and the pending slot is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An arithmetic operation completes this cycle |
| exc_flags_i | input | 3 | Detected flags: bit0 inexact, bit1 underflow, bit2 overflow |
| mul_i | input | 1 | Operation is a multiply |
| res_norm_i | input | 1 | Intermediate result is normalized |
| res_exp_i | input | EXP_W | Biased exponent of the result |
| dest_i | input | 2 | Destination type |
| move_out_i | input | 1 | Operation is a move-out to an integer register or memory |
| ctrl_en_i | input | 8 | Exception-enable byte of the control register |
| stat_acc_i | input | 8 | Accrued-exception byte of the status register |
| next_fp_i | input | 1 | Next floating-point instruction starts |
| wr_en_o | output | 1 | Destination write enable |
| pre_req_o | output | 1 | Pre-instruction exception request |
| post_req_o | output | 1 | Post-instruction exception request |
| handler_o | output | 2 | Handler select, valid with a request |

## Verification
The hardest case to reach is a post-instruction request and a waiting pre-instruction request falling due in the same cycle. Getting there needs a pending exception in the slot, and then an integer-destination event together with the start strobe of the next instruction. The bench builds this in that order and checks that the two requests come out in consecutive cycles. Two related cases are set up the same way: the pending exception being replaced or taken in the same cycle a new one arrives, and reset emptying the slot.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned FLAG_W   = 3;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned F_INEX   = 0;
  localparam int unsigned F_UNFL   = 1;
  localparam int unsigned F_OVFL   = 2;

  typedef enum logic [1:0] {
    DST_FPR = 2'd0,
    DST_INT = 2'd1,
    DST_MEM = 2'd2,
    DST_MEM_ALT = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    H_RESUME = 2'd0,
    H_UNFL   = 2'd1,
    H_OVFL   = 2'd2,
    H_INEX   = 2'd3
  } hsel_e;

  typedef struct packed {
    logic  valid;
    logic  go;
    hsel_e hsel;
  } pend_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int unsigned EXP_W     = 15,
  parameter bit          MUL_QUIRK = 1'b1
) (
  input  logic              op_valid_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              mul_i,
  input  logic              norm_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [1:0]        dest_i,
  output logic              evt_o,
  output logic              to_fpr_o
);
  logic quirk_unfl;

  generate
    if (MUL_QUIRK) begin : g_quirk
      // normalized product with zero biased exponent still reported as underflow
      assign quirk_unfl = mul_i & norm_i & ~|exp_i;
    end else begin : g_noquirk
      logic unused_q;
      assign unused_q   = ^{mul_i, norm_i, exp_i};
      assign quirk_unfl = 1'b0;
    end
  endgenerate

  logic unfl_eff, ovfl_eff;
  assign unfl_eff = flags_i[F_UNFL] | quirk_unfl;
  assign ovfl_eff = flags_i[F_OVFL];
  assign evt_o    = op_valid_i & (unfl_eff | ovfl_eff);
  assign to_fpr_o = (dest_e'(dest_i) == DST_FPR);

  logic unused_inex;
  assign unused_inex = flags_i[F_INEX];
endmodule

// File: rtl/fpx_handler_sel.sv
module fpx_handler_sel
  import fpx_pkg::*;
(
  input  logic [BYTE_W-1:0] en_i,
  input  logic [BYTE_W-1:0] acc_i,
  output hsel_e             hsel_o
);
  always_comb begin
    if (en_i[F_UNFL])                      hsel_o = H_UNFL;
    else if (en_i[F_OVFL])                 hsel_o = H_OVFL;
    else if (en_i[F_INEX] & acc_i[F_INEX]) hsel_o = H_INEX;
    else                                   hsel_o = H_RESUME;
  end

  logic unused_bits;
  assign unused_bits = ^{en_i[BYTE_W-1:F_OVFL+1], acc_i[BYTE_W-1:F_INEX+1]};
endmodule

// File: rtl/fpx_pre_hold.sv
module fpx_pre_hold
  import fpx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  set_i,
  input  hsel_e set_hsel_i,
  input  logic  next_i,
  input  logic  block_i,
  output logic  fire_o,
  output hsel_e fire_hsel_o
);
  pend_t pend_q, pend_d;

  assign fire_o      = pend_q.valid & (pend_q.go | next_i) & ~block_i;
  assign fire_hsel_o = pend_q.hsel;

  always_comb begin
    pend_d = pend_q;
    if (set_i) begin
      pend_d.valid = 1'b1;
      pend_d.go    = 1'b0;
      pend_d.hsel  = set_hsel_i;
    end else if (fire_o) begin
      pend_d = '0;
    end else if (pend_q.valid && next_i) begin
      pend_d.go = 1'b1;    // strobe seen but blocked: fire next cycle
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  // R3: a fired slot with no refill is empty afterwards
  a_r3_slot_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !set_i) |=> !pend_q.valid);
  // R9: a new event always lands in the slot
  a_r9_slot_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (pend_q.valid && pend_q.hsel == $past(set_hsel_i)));
  // R10: a blocked pending request fires the next cycle unless overwritten
  a_r10_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q.valid && next_i && block_i && !set_i) |=> pend_q.go);
endmodule

// File: rtl/fpx_post_seq.sv
module fpx_post_seq
  import fpx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  evt_i,
  input  logic  to_fpr_i,
  input  logic  move_out_i,
  input  hsel_e hsel_i,
  output logic  fire_o,
  output hsel_e fire_hsel_o
);
  logic  post_evt, trap_mo, post_now;
  logic  late_q;
  hsel_e late_hsel_q;

  assign post_evt = evt_i & ~to_fpr_i;
  assign trap_mo  = post_evt & move_out_i & (hsel_i != H_RESUME);
  assign post_now = post_evt & ~trap_mo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      late_q      <= 1'b0;
      late_hsel_q <= H_RESUME;
    end else begin
      late_q      <= trap_mo;
      late_hsel_q <= trap_mo ? hsel_i : H_RESUME;
    end
  end

  assign fire_o      = post_now | late_q;
  assign fire_hsel_o = late_q ? late_hsel_q : hsel_i;

  // R10: usage rule, no immediate post event right behind a trapping move-out
  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_q |-> !post_evt);
  // R5: the deferred slot holds a real handler
  a_r5_late_handler: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_q |-> (late_hsel_q != H_RESUME));
endmodule

// File: rtl/fpx_dispatch.sv
module fpx_dispatch
  import fpx_pkg::*;
#(
  parameter int unsigned EXP_W     = 15,
  parameter bit          MUL_QUIRK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        exc_flags_i,
  input  logic              mul_i,
  input  logic              res_norm_i,
  input  logic [EXP_W-1:0]  res_exp_i,
  input  logic [1:0]        dest_i,
  input  logic              move_out_i,
  input  logic [7:0]        ctrl_en_i,
  input  logic [7:0]        stat_acc_i,
  input  logic              next_fp_i,
  output logic              wr_en_o,
  output logic              pre_req_o,
  output logic              post_req_o,
  output logic [1:0]        handler_o
);
  logic  evt, to_fpr;
  hsel_e hsel;
  logic  post_fire, pre_fire;
  hsel_e post_hsel, pre_hsel;

  fpx_classify #(.EXP_W(EXP_W), .MUL_QUIRK(MUL_QUIRK)) u_classify (
    .op_valid_i (op_valid_i),
    .flags_i    (exc_flags_i),
    .mul_i      (mul_i),
    .norm_i     (res_norm_i),
    .exp_i      (res_exp_i),
    .dest_i     (dest_i),
    .evt_o      (evt),
    .to_fpr_o   (to_fpr)
  );

  fpx_handler_sel u_hsel (
    .en_i   (ctrl_en_i),
    .acc_i  (stat_acc_i),
    .hsel_o (hsel)
  );

  fpx_post_seq u_post (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .to_fpr_i    (to_fpr),
    .move_out_i  (move_out_i),
    .hsel_i      (hsel),
    .fire_o      (post_fire),
    .fire_hsel_o (post_hsel)
  );

  fpx_pre_hold u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (evt & to_fpr),
    .set_hsel_i  (hsel),
    .next_i      (next_fp_i),
    .block_i     (post_fire),
    .fire_o      (pre_fire),
    .fire_hsel_o (pre_hsel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      pre_req_o  <= 1'b0;
      post_req_o <= 1'b0;
      handler_o  <= H_RESUME;
    end else begin
      wr_en_o    <= op_valid_i & ~(evt & to_fpr);
      post_req_o <= post_fire;
      pre_req_o  <= pre_fire;
      handler_o  <= post_fire ? post_hsel : (pre_fire ? pre_hsel : H_RESUME);
    end
  end

  // R2: event to a floating-point register never writes or reports at once
  a_r2_fpr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && evt && dest_i == 2'd0) |=> (!wr_en_o && !post_req_o));
  // R4: event to integer or memory destination always writes
  a_r4_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && dest_i != 2'd0) |=> wr_en_o);
  // R5: trapping move-out writes first, requests one cycle later
  a_r5_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && dest_i != 2'd0 && move_out_i && ctrl_en_i[2:1] != 2'b00)
      |=> (wr_en_o && !post_req_o) ##1 post_req_o);
  // R7: requests exclusive, handler idle without one
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_req_o && post_req_o));
  a_r7_handler_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_req_o && !post_req_o) |-> (handler_o == 2'd0));
  // R1: no event means no request raised
  a_r1_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !evt && !next_fp_i && !pre_req_o && !post_req_o && !u_post.late_q
      && !u_pre.pend_q.valid) |=> (wr_en_o && !pre_req_o && !post_req_o));
endmodule

// File: tb/fpx_dispatch_tb.sv
module fpx_dispatch_tb;
  localparam int EXP_W = 15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             op_valid, mul, norm, move_out, next_fp;
  logic [2:0]       flags;
  logic [EXP_W-1:0] rexp;
  logic [1:0]       dest;
  logic [7:0]       en, acc;
  logic             wr_en, pre_req, post_req;
  logic [1:0]       handler;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fpx_dispatch #(.EXP_W(EXP_W), .MUL_QUIRK(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .exc_flags_i(flags),
    .mul_i(mul), .res_norm_i(norm), .res_exp_i(rexp), .dest_i(dest),
    .move_out_i(move_out), .ctrl_en_i(en), .stat_acc_i(acc), .next_fp_i(next_fp),
    .wr_en_o(wr_en), .pre_req_o(pre_req), .post_req_o(post_req), .handler_o(handler)
  );

  function automatic logic [1:0] ref_hsel(input logic [7:0] e, input logic [7:0] a);
    if (e[1])             return 2'd1;
    else if (e[2])        return 2'd2;
    else if (e[0] && a[0]) return 2'd3;
    else                  return 2'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outputs packed as {wr, pre, post, handler}
  task automatic check_out(input string req, input logic w, input logic pr,
                           input logic po, input logic [1:0] h);
    check(req, {3'b0, wr_en, pre_req, post_req, handler}, {3'b0, w, pr, po, h});
  endtask

  task automatic idle_inputs();
    op_valid = 0; flags = 0; mul = 0; norm = 0; rexp = '1; dest = 0;
    move_out = 0; en = 0; acc = 0; next_fp = 0;
  endtask

  // drive one operation at a negedge; return at the next negedge
  task automatic op(input logic [2:0] f, input logic [1:0] d, input logic mo,
                    input logic [7:0] e, input logic [7:0] a, input logic nx);
    @(negedge clk);
    op_valid = 1; flags = f; dest = d; move_out = mo; en = e; acc = a; next_fp = nx;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic strobe_next();
    @(negedge clk);
    next_fp = 1;
    @(negedge clk);
    next_fp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    #1;
    check_out("R11 outputs in reset", 0, 0, 0, 2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_no_event();
    op(3'b001, 2'd0, 0, 8'h07, 8'h01, 0);
    check_out("R1 inexact only to fpr", 1, 0, 0, 2'd0);
    op(3'b000, 2'd2, 1, 8'h07, 8'h01, 0);
    check_out("R1 clean move-out", 1, 0, 0, 2'd0);
    @(negedge clk);
    check_out("R1 idle after op", 0, 0, 0, 2'd0);
  endtask

  task automatic t_fpr_pending();
    op(3'b010, 2'd0, 0, 8'h04, 8'h00, 0);
    check_out("R2 fpr no write no request", 0, 0, 0, 2'd0);
    repeat (2) @(negedge clk);
    check_out("R2 still held", 0, 0, 0, 2'd0);
    strobe_next();
    check_out("R3 pre on next instruction", 0, 1, 0, 2'd2);
    @(negedge clk);
    check_out("R7 single-cycle request", 0, 0, 0, 2'd0);
    strobe_next();
    check_out("R3 slot empty after take", 0, 0, 0, 2'd0);
  endtask

  task automatic t_post();
    op(3'b100, 2'd1, 0, 8'h01, 8'h01, 0);
    check_out("R4 int dest post", 1, 0, 1, 2'd3);
    op(3'b010, 2'd2, 1, 8'h01, 8'h00, 0);
    check_out("R4 move-out resume immediate", 1, 0, 1, 2'd0);
    op(3'b010, 2'd3, 0, 8'h02, 8'h00, 0);
    check_out("R4 dest code 3 as memory", 1, 0, 1, 2'd1);
  endtask

  task automatic t_moveout_trap();
    op(3'b010, 2'd2, 1, 8'h02, 8'h00, 0);
    check_out("R5 write before request", 1, 0, 0, 2'd0);
    @(negedge clk);
    check_out("R5 request after write", 0, 0, 1, 2'd1);
    @(negedge clk);
    check_out("R5 done", 0, 0, 0, 2'd0);
  endtask

  task automatic t_cascade();
    logic [7:0] ens [6];
    logic [7:0] accs[6];
    ens[0] = 8'h00; accs[0] = 8'hFF;
    ens[1] = 8'h01; accs[1] = 8'hFE;
    ens[2] = 8'h01; accs[2] = 8'h01;
    ens[3] = 8'h05; accs[3] = 8'h01;
    ens[4] = 8'h06; accs[4] = 8'h01;
    ens[5] = 8'hF8; accs[5] = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      op(3'b100, 2'd1, 0, ens[i], accs[i], 0);
      check_out($sformatf("R6 cascade case %0d", i), 1, 0, 1, ref_hsel(ens[i], accs[i]));
    end
  endtask

  task automatic t_quirk();
    @(negedge clk);
    op_valid = 1; mul = 1; norm = 1; rexp = '0; dest = 2'd1; en = 8'h02;
    @(negedge clk);
    idle_inputs();
    check_out("R8 zero-exponent product reported", 1, 0, 1, 2'd1);
    @(negedge clk);
    op_valid = 1; mul = 1; norm = 1; rexp = 1; dest = 2'd1; en = 8'h02;
    @(negedge clk);
    idle_inputs();
    check_out("R8 nonzero exponent quiet", 1, 0, 0, 2'd0);
    @(negedge clk);
    op_valid = 1; mul = 1; norm = 0; rexp = '0; dest = 2'd1; en = 8'h02;
    @(negedge clk);
    idle_inputs();
    check_out("R8 unnormalized quiet", 1, 0, 0, 2'd0);
  endtask

  task automatic t_replace();
    op(3'b010, 2'd0, 0, 8'h04, 8'h00, 0);
    op(3'b100, 2'd0, 0, 8'h01, 8'h01, 0);
    strobe_next();
    check_out("R9 newer pending replaces older", 0, 1, 0, 2'd3);
    op(3'b010, 2'd0, 0, 8'h02, 8'h00, 0);
    op(3'b100, 2'd0, 0, 8'h04, 8'h00, 1);
    check_out("R9 older taken with new arrival", 0, 1, 0, 2'd1);
    strobe_next();
    check_out("R9 new one stays pending", 0, 1, 0, 2'd2);
  endtask

  task automatic t_collision();
    op(3'b010, 2'd0, 0, 8'h01, 8'h01, 0);
    op(3'b100, 2'd1, 0, 8'h04, 8'h00, 1);
    check_out("R10 post first", 1, 0, 1, 2'd2);
    @(negedge clk);
    check_out("R10 pre follows", 0, 1, 0, 2'd3);
    @(negedge clk);
    check_out("R10 settled", 0, 0, 0, 2'd0);
  endtask

  task automatic t_reset_clears();
    op(3'b010, 2'd0, 0, 8'h02, 8'h00, 0);
    do_reset();
    strobe_next();
    check_out("R11 pending emptied by reset", 0, 0, 0, 2'd0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_out("R11 reset state", 0, 0, 0, 2'd0);
    rst_n = 1;
    t_no_event();
    t_fpr_pending();
    t_post();
    t_moveout_trap();
    t_cascade();
    t_quirk();
    t_replace();
    t_collision();
    t_reset_clears();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule